// File: doc/BRIEF.md
# Configuration Register Bank with Persistence Control

This block holds a small set of configuration registers and decides when their contents are copied into a non-volatile shadow store through an external programming engine. A write-control bit, kept in bit 3 of the address register, picks the policy. When it is clear, each accepted register write is followed by a single-register persistence request. When it is set, writes change only the volatile register, and persistence happens only when a store command copies the whole bank. A write to the address register is always persisted, whatever the policy.

The shadow copy lives inside the block and is cleared only by the power-on reset. Each ordinary reset releases into a restore phase that reloads the registers from the shadow copy, one entry per cycle. The bank reports ready only after that phase. The programming engine is reached through a level request that carries an index and a data value and that is answered by a one-cycle acknowledge. The acknowledge also updates the shadow copy. The three-bit slave-address nibble is taken from the shadow copy of the address register, so it changes only once a new address value has been accepted by the engine. While the block is busy, writes are held off: the writer must wait until busy is low.

Top module: `cfg_store_bank`

## Requirements
- R1: After power-on reset, every register, the shadow copy, the write-control bit and `slave_nib` are zero, and once restore completes `busy` is low.
- R2: When reset is released, the registers reload from the shadow copy in ascending index order, one per cycle. `ready` rises after exactly NUM_REGS clock edges, and `busy` stays high until then.
- R3: With the write-control bit (bit 3 of register ADDR_IDX, default 3) at 0, an accepted write to any register starts one request that carries that register's index and its new value.
- R4: With the write-control bit at 1, an accepted write to any register other than ADDR_IDX changes the register and starts no request.
- R5: An accepted write to register ADDR_IDX always starts a request for that register, whatever the write-control bit holds.
- R6: A store command copies every register, with one request per register in ascending index order from 0 to NUM_REGS-1.
- R7: A store command that arrives while the block is busy is queued, and the copy runs after the current job. Several store commands that arrive before that copy starts merge into one copy.
- R8: A write and a store command in the same cycle produce one full-bank copy that carries the new value, and no separate single-register request.
- R9: `busy` is high during restore, during a job, and while a copy is queued. A `wr_en` pulse while `busy` is high leaves every register unchanged.
- R10: `slave_nib` equals bits 2 to 0 of the shadow copy of register ADDR_IDX. It changes only when the engine acknowledges a request for that register, and not when the register is written.
- R11: `ee_req` stays high with `ee_addr` and `ee_data` stable until `ee_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the shadow copy |
| rst_n | input | 1 | Reset, active low; its release starts a restore |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register index to write |
| wr_data | input | DW | Write data |
| store_cmd | input | 1 | Strobe that requests a copy of the whole bank |
| busy | output | 1 | Writes are held off while high |
| ready | output | 1 | High once restore has completed |
| regs_flat | output | NUM_REGS*DW | All register contents, register i at bits i*DW and up |
| slave_nib | output | 3 | Slave-address nibble from the persisted address register |
| ee_req | output | 1 | Persistence request to the programming engine |
| ee_addr | output | AW | Index of the register being persisted |
| ee_data | output | DW | Value being persisted |
| ee_ack | input | 1 | One-cycle completion from the engine |

## Verification
Two functions can fall in the same cycle. An automatic single-register persist can start in the same cycle as a full-bank store, and a store command can arrive in the very cycle the current job ends. The bench provokes the first case by raising `wr_en` and `store_cmd` on one edge while the write-control bit is clear. It provokes a related case by pulsing `store_cmd` twice while a single-register job is still waiting for its acknowledge. In both cases the scoreboard expects exactly one ascending sequence of full-bank requests, so any extra single request or a second copy shows up as an unexpected item.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  typedef enum logic [1:0] {
    ST_RESTORE = 2'd0,
    ST_IDLE    = 2'd1,
    ST_SINGLE  = 2'd2,
    ST_FULL    = 2'd3
  } bank_state_e;

  // A write is persisted at once when it targets the address register
  // or when automatic persistence is selected (control bit clear).
  function automatic logic needs_persist(input int unsigned idx,
                                         input int unsigned addr_idx,
                                         input logic        wc);
    return (idx == addr_idx) || !wc;
  endfunction

  function automatic logic idx_in_range(input int unsigned idx,
                                        input int unsigned n);
    return idx < n;
  endfunction

endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NUM_REGS = 4,
  parameter int DW       = 8,
  parameter int AW       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic [AW-1:0]          load_idx,
  input  logic [DW-1:0]          load_val,
  input  logic                   wr_acc,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_idx,
  output logic [DW-1:0]          rd_val,
  output logic [NUM_REGS*DW-1:0] regs_flat
);

  logic [DW-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (load_en && load_idx == AW'(i)) begin
        regs[i] <= load_val;
      end else if (wr_acc && wr_addr == AW'(i)) begin
        regs[i] <= wr_data;
      end
    end
    assign regs_flat[i*DW +: DW] = regs[i];
  end

  assign rd_val = regs[rd_idx];

endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
  parameter int NUM_REGS = 4,
  parameter int DW       = 8,
  parameter int AW       = 2,
  parameter int ADDR_IDX = 3
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_idx,
  input  logic [DW-1:0] upd_val,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_val,
  output logic [2:0]    addr_nib
);

  logic [DW-1:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        mem[i] <= '0;
      end else if (upd_en && upd_idx == AW'(i)) begin
        mem[i] <= upd_val;
      end
    end
  end

  assign rd_val   = mem[rd_idx];
  assign addr_nib = mem[ADDR_IDX][2:0];

endmodule

// File: rtl/cfg_persist_ctrl.sv
module cfg_persist_ctrl
  import cfg_bank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int AW       = 2,
  parameter int ADDR_IDX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          store_cmd,
  input  logic          wc,
  input  logic          ee_ack,
  output logic          busy,
  output logic          ready,
  output logic          wr_acc,
  output logic          restore_en,
  output logic [AW-1:0] cur_idx,
  output logic          ee_req,
  output logic          launch_full,
  output logic          job_end
);

  localparam logic [AW-1:0] LAST_IDX = AW'(NUM_REGS - 1);

  bank_state_e state;
  logic        pend_all;
  logic        want_full;
  logic        launch_single;
  logic        last_ent;

  assign busy       = (state != ST_IDLE) || pend_all;
  assign ready      = (state != ST_RESTORE);
  assign restore_en = (state == ST_RESTORE);
  assign ee_req     = (state == ST_SINGLE) || (state == ST_FULL);

  assign wr_acc = wr_en && !busy && idx_in_range(32'(wr_addr), NUM_REGS);

  assign last_ent  = (cur_idx == LAST_IDX);
  assign want_full = store_cmd || pend_all;
  assign job_end   = ee_ack && ee_req &&
                     ((state == ST_SINGLE) || last_ent);

  assign launch_full   = want_full && ((state == ST_IDLE) || job_end);
  assign launch_single = (state == ST_IDLE) && !want_full && wr_acc &&
                         needs_persist(32'(wr_addr), ADDR_IDX, wc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RESTORE;
      cur_idx  <= '0;
      pend_all <= 1'b0;
    end else begin
      pend_all <= launch_full ? 1'b0 : (pend_all || store_cmd);
      unique case (state)
        ST_RESTORE: begin
          if (last_ent) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
          end else begin
            cur_idx <= cur_idx + AW'(1);
          end
        end
        ST_IDLE: begin
          if (launch_full) begin
            state   <= ST_FULL;
            cur_idx <= '0;
          end else if (launch_single) begin
            state   <= ST_SINGLE;
            cur_idx <= wr_addr;
          end
        end
        ST_SINGLE: begin
          if (ee_ack) begin
            state   <= launch_full ? ST_FULL : ST_IDLE;
            cur_idx <= '0;
          end
        end
        ST_FULL: begin
          if (ee_ack) begin
            if (last_ent) begin
              state   <= launch_full ? ST_FULL : ST_IDLE;
              cur_idx <= '0;
            end else begin
              cur_idx <= cur_idx + AW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_store_bank.sv
module cfg_store_bank #(
  parameter int NUM_REGS = 4,
  parameter int DW       = 8,
  parameter int ADDR_IDX = NUM_REGS - 1,
  localparam int AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   store_cmd,
  output logic                   busy,
  output logic                   ready,
  output logic [NUM_REGS*DW-1:0] regs_flat,
  output logic [2:0]             slave_nib,
  output logic                   ee_req,
  output logic [AW-1:0]          ee_addr,
  output logic [DW-1:0]          ee_data,
  input  logic                   ee_ack
);

  localparam int WC_BIT = ADDR_IDX * DW + 3;

  // Named internal events, observed by the bound checker.
  logic          wr_acc;
  logic          wc;
  logic          restore_en;
  logic          launch_full;
  logic          job_end;
  logic          shadow_upd;
  logic [AW-1:0] cur_idx;
  logic [DW-1:0] shadow_rd;
  logic [DW-1:0] reg_rd;

  assign wc         = regs_flat[WC_BIT];
  assign shadow_upd = ee_req && ee_ack;
  assign ee_addr    = cur_idx;
  assign ee_data    = reg_rd;

  cfg_persist_ctrl #(
    .NUM_REGS(NUM_REGS), .AW(AW), .ADDR_IDX(ADDR_IDX)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .store_cmd  (store_cmd),
    .wc         (wc),
    .ee_ack     (ee_ack),
    .busy       (busy),
    .ready      (ready),
    .wr_acc     (wr_acc),
    .restore_en (restore_en),
    .cur_idx    (cur_idx),
    .ee_req     (ee_req),
    .launch_full(launch_full),
    .job_end    (job_end)
  );

  cfg_regfile #(
    .NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (restore_en),
    .load_idx (cur_idx),
    .load_val (shadow_rd),
    .wr_acc   (wr_acc),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_idx   (cur_idx),
    .rd_val   (reg_rd),
    .regs_flat(regs_flat)
  );

  cfg_shadow #(
    .NUM_REGS(NUM_REGS), .DW(DW), .AW(AW), .ADDR_IDX(ADDR_IDX)
  ) u_shadow (
    .clk     (clk),
    .por_n   (por_n),
    .upd_en  (shadow_upd),
    .upd_idx (cur_idx),
    .upd_val (reg_rd),
    .rd_idx  (cur_idx),
    .rd_val  (shadow_rd),
    .addr_nib(slave_nib)
  );

endmodule

// File: rtl/cfg_store_bank_chk.sv
module cfg_store_bank_chk #(
  parameter int NUM_REGS = 4,
  parameter int DW       = 8,
  parameter int ADDR_IDX = 3,
  localparam int AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ready,
  input logic                   busy,
  input logic                   wr_acc,
  input logic [AW-1:0]          wr_addr,
  input logic [DW-1:0]          wr_data,
  input logic                   store_cmd,
  input logic                   wc,
  input logic                   ee_req,
  input logic                   ee_ack,
  input logic [AW-1:0]          ee_addr,
  input logic [DW-1:0]          ee_data,
  input logic [NUM_REGS*DW-1:0] regs_flat,
  input logic [2:0]             slave_nib
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> ee_req && $stable(ee_addr) && $stable(ee_data)); // R11

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ready && busy |=> $stable(regs_flat)); // R9

  AST_RESTORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> busy); // R2

  AST_AUTO_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && !wc && !store_cmd |=>
      ee_req && ee_addr == $past(wr_addr) && ee_data == $past(wr_data)); // R3

  AST_DEFER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && wc && !store_cmd && wr_addr != AW'(ADDR_IDX) |=> !ee_req); // R4

  AST_ADDR_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && wr_addr == AW'(ADDR_IDX) |=> ee_req); // R5

  AST_FULL_ABSORBS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && store_cmd |=> ee_req && ee_addr == '0); // R8

  AST_NIB_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !(ee_req && ee_ack && ee_addr == AW'(ADDR_IDX)) |=>
      $stable(slave_nib)); // R10

endmodule

bind cfg_store_bank cfg_store_bank_chk #(
  .NUM_REGS(NUM_REGS), .DW(DW), .ADDR_IDX(ADDR_IDX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .busy     (busy),
  .wr_acc   (wr_acc),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .store_cmd(store_cmd),
  .wc       (wc),
  .ee_req   (ee_req),
  .ee_ack   (ee_ack),
  .ee_addr  (ee_addr),
  .ee_data  (ee_data),
  .regs_flat(regs_flat),
  .slave_nib(slave_nib)
);

// File: tb/tb_cfg_store_bank.sv
module tb_cfg_store_bank;

  localparam int NR  = 4;
  localparam int DW  = 8;
  localparam int AI  = 3;
  localparam int AW  = 2;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          por_n = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, store_cmd = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy, ready, ee_req, ee_ack;
  logic [NR*DW-1:0] regs_flat;
  logic [2:0]    slave_nib;
  logic [AW-1:0] ee_addr;
  logic [DW-1:0] ee_data;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  cfg_store_bank #(.NUM_REGS(NR), .DW(DW), .ADDR_IDX(AI)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .store_cmd(store_cmd),
    .busy(busy), .ready(ready), .regs_flat(regs_flat),
    .slave_nib(slave_nib), .ee_req(ee_req), .ee_addr(ee_addr),
    .ee_data(ee_data), .ee_ack(ee_ack)
  );

  // Programming engine model: acknowledges each request after LAT cycles.
  int eng_cnt = 0;
  always_ff @(posedge clk) begin
    ee_ack <= 1'b0;
    if (ee_req && !ee_ack) begin
      if (eng_cnt == LAT - 1) begin
        ee_ack  <= 1'b1;
        eng_cnt <= 0;
      end else begin
        eng_cnt <= eng_cnt + 1;
      end
    end else begin
      eng_cnt <= 0;
    end
  end

  logic [DW-1:0] exp_reg [NR];
  logic [DW-1:0] exp_sh  [NR];
  logic [AW+DW-1:0] exp_q [$];
  string            tag_q [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input int idx, input logic [DW-1:0] d, input string tag);
    exp_q.push_back({AW'(idx), d});
    tag_q.push_back(tag);
    exp_sh[idx] = d;
  endtask

  task automatic expect_full(input string tag);
    for (int i = 0; i < NR; i++) expect_item(i, exp_reg[i], tag);
  endtask

  // Monitor: pops expected persistence items and checks request stability.
  logic          held = 1'b0;
  logic [AW-1:0] held_a;
  logic [DW-1:0] held_d;
  always @(negedge clk) begin
    if (rst_n && ee_req && !held) begin
      held   = 1'b1;
      held_a = ee_addr;
      held_d = ee_data;
    end
    if (rst_n && ee_req && ee_ack) begin
      chk("R11 request stable until ack", {ee_addr, ee_data}, {held_a, held_d});
      held = 1'b0;
      if (exp_q.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL R4/R8 unexpected request actual=%0h expected=none",
                 {ee_addr, ee_data});
      end else begin
        logic [AW+DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {ee_addr, ee_data}, e);
      end
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d, input logic with_store);
    logic wc_old;
    while (busy) @(negedge clk);
    wc_old    = exp_reg[AI][3];
    wr_en     = 1'b1;
    wr_addr   = AW'(a);
    wr_data   = d;
    store_cmd = with_store;
    @(negedge clk);
    wr_en     = 1'b0;
    store_cmd = 1'b0;
    exp_reg[a] = d;
    if (with_store) expect_full("R8 write with store gives one copy");
    else if (a == AI) expect_item(a, d, "R5 address register persists");
    else if (!wc_old) expect_item(a, d, "R3 automatic persist");
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NR; i++) chk(tag, regs_flat[i*DW +: DW], exp_reg[i]);
  endtask

  task automatic reset_and_count(input logic with_por);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!ready) chk("R2 busy during restore", busy, 1);
    end while (!ready && n < 100);
    chk("R2 restore length", n, NR);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin exp_reg[i] = '0; exp_sh[i] = '0; end

    // R1, R2: power-on reset then restore
    reset_and_count(1'b1);
    check_regs("R1 registers zero after power-on");
    chk("R1 nibble zero", slave_nib, 0);
    chk("R1 not busy", busy, 0);

    // R3: automatic persistence with control bit clear
    wr(0, 8'h11, 1'b0); wait_idle();
    wr(2, 8'h22, 1'b0); wait_idle();
    check_regs("R3 registers after writes");

    // R10, R9: address write, nibble waits for ack, write held off
    wr(AI, 8'h05, 1'b0);
    chk("R10 nibble unchanged before ack", slave_nib, 0);
    chk("R9 busy during job", busy, 1);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h99;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 write while busy ignored", regs_flat[1*DW +: DW], 8'h00);
    wait_idle();
    chk("R10 nibble after ack", slave_nib, 5);

    // R4, R5: deferred mode
    wr(AI, 8'h0D, 1'b0); wait_idle();
    chk("R10 nibble in deferred mode", slave_nib, 5);
    wr(1, 8'h44, 1'b0);
    chk("R4 no job after deferred write", busy, 0);
    repeat (6) @(negedge clk);
    chk("R4 register updated", regs_flat[1*DW +: DW], 8'h44);
    wr(AI, 8'h0B, 1'b0); wait_idle();
    chk("R5 nibble follows address write", slave_nib, 3);

    // R6: full copy on store
    wr(0, 8'h55, 1'b0);
    wr(2, 8'h66, 1'b0);
    @(negedge clk);
    store_cmd = 1'b1;
    expect_full("R6 full copy ascending");
    @(negedge clk);
    store_cmd = 1'b0;
    wait_idle();

    // R7: stores queued behind a job, merged into one copy
    wr(AI, 8'h02, 1'b0);
    store_cmd = 1'b1;
    expect_full("R7 queued copy");
    @(negedge clk);
    store_cmd = 1'b0;
    @(negedge clk);
    store_cmd = 1'b1;
    @(negedge clk);
    store_cmd = 1'b0;
    chk("R7 busy while queued", busy, 1);
    wait_idle();

    // R8: write and store in one cycle
    wr(1, 8'h77, 1'b1);
    wait_idle();
    check_regs("R8 registers after merged copy");

    // R2: warm reset restores the persisted values
    wr(AI, 8'h0A, 1'b0); wait_idle();
    wr(0, 8'hEE, 1'b0);
    repeat (6) @(negedge clk);
    reset_and_count(1'b0);
    for (int i = 0; i < NR; i++) exp_reg[i] = exp_sh[i];
    check_regs("R2 restored from shadow");
    chk("R2 unpersisted value dropped", regs_flat[0 +: DW], 8'h55);
    chk("R10 nibble after restore", slave_nib, 2);

    repeat (4) @(negedge clk);
    chk("R6 all expected requests seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule